// File: doc/BRIEF.md
# Strobe-Paced Serial ADC Conversion Sequencer

This block is the host-side controller for a 12-bit serial ADC that runs its conversions from its own on-chip oscillator. A transfer begins when the block shifts an 8-bit command into the converter. The converter starts sampling on the falling clock edge that ends that byte. The block then releases chip select, so the shared serial bus is free for other devices while the converter works. The converter's conversion time depends on supply and temperature, so the block does not count clocks. It watches the converter's busy/done strobe, which is low while converting and high once the result is ready. It passes that line through a synchroniser and treats only a low-to-high transition as completion.

On completion the block selects the converter again and clocks in a 16-bit readout frame. The first 12 bits are the result, MSB first, and the remaining bits are zero padding. When chaining is enabled, the next command byte travels out during the first eight clocks of that same readout frame. In steady state each conversion then costs two byte transfers instead of three, and the block goes straight back to waiting on the strobe. A programmable watchdog ends a wait whose strobe never rises: it flags an error and returns the block to idle.

Top module: `adc_strobe_seq`

## Requirements
- R1: While reset is held and directly after it, `cs_n`=1, `sclk`=0, `mosi`=0, `bus_grant`=0, `busy`=0, `timeout_err`=0 and `result_valid`=0.
- R2: A `start` pulse in idle pulls `cs_n` low and sends `cmd_in` as 8 SCLK pulses (clock idles low), MSB first. `mosi` changes after falling edges and is stable at rising edges. Afterwards `cs_n` returns high.
- R3: Between the command frame and the readout frame, `cs_n` stays high, `sclk` stays low and `bus_grant` is high.
- R4: `adc_strobe` passes through SYNC_STAGES flip-flops. Only a low-to-high transition seen during the wait ends it. A strobe that is already high, or stays high, does not start a readout.
- R5: A readout frame lasts 16 SCLK pulses with `miso` sampled on rising edges. The first 12 bits become `result[11:0]`, MSB first, and the last 4 are discarded. `result_valid` pulses for exactly one cycle when the frame ends.
- R6: If `chain_en` is high when a readout frame starts, `cmd_in` is sent MSB first in its first 8 bits and the block then waits for the strobe again, for 16 SCLK pulses per conversion. Otherwise `mosi` stays 0 during the readout and the block goes idle, for 24 pulses per conversion.
- R7: A wait that reaches `timeout_lim` system clocks without a strobe rise sets `timeout_err`, drops `bus_grant` and `busy`, and returns to idle. `timeout_err` clears at the next accepted `start`.
- R8: `start` is ignored while `busy` is high. No extra frame is sent and the pending result is unchanged.
- R9: `busy` is high from an accepted `start` until the block returns to idle.
- R10: Each SCLK high phase and each SCLK low phase lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion with `cmd_in` (accepted only in idle) |
| cmd_in | input | CMD_BITS | Command byte for the converter |
| chain_en | input | 1 | Send `cmd_in` during the coming readout frame |
| timeout_lim | input | TMO_W | Wait limit in system clocks |
| adc_strobe | input | 1 | Converter busy/done line, asynchronous |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to converter |
| bus_grant | output | 1 | High while the bus is released during a conversion |
| busy | output | 1 | Sequence in progress |
| result | output | RES_BITS | Last conversion result |
| result_valid | output | 1 | One-cycle pulse with a new `result` |
| timeout_err | output | 1 | Strobe wait timed out |

## Verification
The assertions check, on every cycle, that SCLK is never active with chip select released or while the bus is granted. They also check that `result_valid` and a detected strobe rise are single-cycle pulses, that the watchdog count restarts at zero on each wait, and that a timeout only follows a granted wait and leaves the block not busy. The bench scenarios cover everything that depends on the converter's side of the link. These are the values of results shifted back, the exact command byte received, the SCLK count per conversion with and without chaining, the SCLK phase length, and the rejection of a strobe that never falls and rises. They also cover the timing of the watchdog and the discarding of a `start` issued mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_WAIT = 2'd2,
      ST_READ = 2'd3
   } seq_state_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adc_seq_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= async_in;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign level = chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end

   assign rise = level & ~prev;

   // R4: a detected transition lasts one cycle only
   p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expired
);
   logic [W-1:0] cnt;

   generate
      if (W < 2) begin : g_bad_width
         $error("adc_seq_timer: W must be at least 2");
      end
   endgenerate

   assign expired = run && (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   // R7: every wait is timed from zero
   p_fresh_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
   parameter int CLK_DIV    = 4,
   parameter int FRAME_BITS = 16,
   parameter int NB_W       = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [NB_W-1:0]       nbits,
   input  logic [FRAME_BITS-1:0] tx_word,
   input  logic                  miso,
   output logic                  sclk,
   output logic                  mosi,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic                  done
);
   logic                  active;
   logic [FRAME_BITS-1:0] tx_sr;
   logic [NB_W-1:0]       bits_left;
   logic                  tick;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("adc_seq_shift: CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_div_none
         assign tick = 1'b1;
      end else begin : g_div_cnt
         localparam int DW = $clog2(CLK_DIV);
         logic [DW-1:0] div_cnt;
         assign tick = (div_cnt == DW'(CLK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || go || !active) div_cnt <= '0;
            else if (tick)               div_cnt <= '0;
            else                         div_cnt <= div_cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         sclk      <= 1'b0;
         mosi      <= 1'b0;
         tx_sr     <= '0;
         rx_word   <= '0;
         bits_left <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            active    <= 1'b1;
            sclk      <= 1'b0;
            mosi      <= tx_word[FRAME_BITS-1];
            tx_sr     <= tx_word << 1;
            bits_left <= nbits;
            rx_word   <= '0;
         end else if (active && tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_word <= {rx_word[FRAME_BITS-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bits_left == NB_W'(1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
                  mosi   <= 1'b0;
               end else begin
                  bits_left <= bits_left - 1'b1;
                  mosi      <= tx_sr[FRAME_BITS-1];
                  tx_sr     <= tx_sr << 1;
               end
            end
         end
      end
   end

   // R10: the serial clock only runs inside a frame
   p_sclk_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sclk);
   // R5: completion is a single-cycle event
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq
   import adc_seq_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CMD_BITS    = 8,
   parameter int RES_BITS    = 12,
   parameter int FRAME_BITS  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CMD_BITS-1:0] cmd_in,
   input  logic                chain_en,
   input  logic [TMO_W-1:0]    timeout_lim,
   input  logic                adc_strobe,
   input  logic                miso,
   output logic                sclk,
   output logic                cs_n,
   output logic                mosi,
   output logic                bus_grant,
   output logic                busy,
   output logic [RES_BITS-1:0] result,
   output logic                result_valid,
   output logic                timeout_err
);
   localparam int NB_W     = $clog2(FRAME_BITS + 1);
   localparam int PAD_BITS = FRAME_BITS - CMD_BITS;
   localparam int TAIL     = FRAME_BITS - RES_BITS;

   generate
      if (FRAME_BITS <= CMD_BITS) begin : g_bad_cmd
         $error("adc_strobe_seq: FRAME_BITS must exceed CMD_BITS");
      end
      if (FRAME_BITS <= RES_BITS) begin : g_bad_res
         $error("adc_strobe_seq: FRAME_BITS must exceed RES_BITS");
      end
   endgenerate

   seq_state_t            state;
   logic                  chain_q;
   logic                  go;
   logic [NB_W-1:0]       go_len;
   logic [FRAME_BITS-1:0] go_word;
   logic [FRAME_BITS-1:0] rx_word;
   logic                  sh_done;
   logic                  strobe_lvl;
   logic                  strobe_rise;
   logic                  tmo_hit;
   logic                  unused_tail;

   assign unused_tail = ^{rx_word[TAIL-1:0], strobe_lvl};

   adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (adc_strobe),
      .level    (strobe_lvl),
      .rise     (strobe_rise)
   );

   adc_seq_timer #(.W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_WAIT),
      .limit   (timeout_lim),
      .expired (tmo_hit)
   );

   adc_seq_shift #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS), .NB_W(NB_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .nbits   (go_len),
      .tx_word (go_word),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .rx_word (rx_word),
      .done    (sh_done)
   );

   always_comb begin
      go      = 1'b0;
      go_len  = NB_W'(CMD_BITS);
      go_word = '0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               go      = 1'b1;
               go_word = {cmd_in, {PAD_BITS{1'b0}}};
            end
         end
         ST_WAIT: begin
            if (strobe_rise) begin
               go      = 1'b1;
               go_len  = NB_W'(FRAME_BITS);
               go_word = chain_en ? {cmd_in, {PAD_BITS{1'b0}}} : '0;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cs_n         <= 1'b1;
         bus_grant    <= 1'b0;
         busy         <= 1'b0;
         chain_q      <= 1'b0;
         result       <= '0;
         result_valid <= 1'b0;
         timeout_err  <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state       <= ST_CMD;
                  cs_n        <= 1'b0;
                  busy        <= 1'b1;
                  timeout_err <= 1'b0;
               end
            end
            ST_CMD: begin
               if (sh_done) begin
                  state     <= ST_WAIT;
                  cs_n      <= 1'b1;
                  bus_grant <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (strobe_rise) begin
                  state     <= ST_READ;
                  cs_n      <= 1'b0;
                  bus_grant <= 1'b0;
                  chain_q   <= chain_en;
               end else if (tmo_hit) begin
                  state       <= ST_IDLE;
                  bus_grant   <= 1'b0;
                  busy        <= 1'b0;
                  timeout_err <= 1'b1;
               end
            end
            ST_READ: begin
               if (sh_done) begin
                  result       <= rx_word[FRAME_BITS-1 -: RES_BITS];
                  result_valid <= 1'b1;
                  cs_n         <= 1'b1;
                  if (chain_q) begin
                     state     <= ST_WAIT;
                     bus_grant <= 1'b1;
                  end else begin
                     state <= ST_IDLE;
                     busy  <= 1'b0;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: the bus is only granted with the device deselected and the clock quiet
   p_grant_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> (cs_n && !sclk));
   // R2: no clock pulse reaches a deselected device
   p_cs_gates_sclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R5: new result announced for one cycle
   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   // R7: a timeout only ends a granted wait and leaves the block idle
   p_timeout_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> (!busy && $past(bus_grant)));
   // R9: an idle block holds the bus released and not granted
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && !bus_grant));
endmodule

// File: tb/sim_adc_strobe_seq.sv
module sim_adc_strobe_seq;
   localparam int DIV      = 4;
   localparam int TW       = 16;
   localparam int CONV_CYC = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  cmd_in = 8'h00;
   logic        chain_en = 1'b0;
   logic [TW-1:0] timeout_lim = TW'(2000);
   logic        adc_strobe;
   logic        miso;
   logic        sclk, cs_n, mosi, bus_grant, busy, result_valid, timeout_err;
   logic [11:0] result;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   adc_strobe_seq #(.CLK_DIV(DIV), .TMO_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in),
      .chain_en(chain_en), .timeout_lim(timeout_lim), .adc_strobe(adc_strobe),
      .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .bus_grant(bus_grant),
      .busy(busy), .result(result), .result_valid(result_valid),
      .timeout_err(timeout_err)
   );

   function automatic logic [11:0] fexp(input logic [7:0] c);
      return {c[3:0], c};
   endfunction

   // converter model
   logic        conv_enable = 1'b1;
   logic        hold_high = 1'b0;
   logic        ready = 1'b0;
   logic [11:0] res_reg = 12'h000;
   logic [11:0] pending = 12'h000;
   logic [11:0] out_word = 12'h000;
   logic [7:0]  rx_cmd = 8'h00;
   logic [7:0]  last_cmd = 8'h00;
   int          fcnt = 0;
   int          bitpos = 0;
   int          conv_timer = 0;
   int          sclk_n = 0;
   bit          grant_bad = 1'b0;

   initial begin
      adc_strobe = 1'b1;
      miso = 1'b0;
   end

   always @(negedge cs_n) begin
      out_word = ready ? res_reg : 12'hFFF;
      bitpos = 0;
      fcnt = 0;
      miso = out_word[11];
   end

   always @(posedge sclk) begin
      sclk_n++;
      if (!cs_n) begin
         if (fcnt < 8) rx_cmd = {rx_cmd[6:0], mosi};
         fcnt++;
      end
   end

   always @(negedge sclk) begin
      if (!cs_n) begin
         bitpos++;
         miso = (bitpos < 12) ? out_word[11-bitpos] : 1'b0;
         if (fcnt == 8 && rx_cmd[7]) begin
            last_cmd = rx_cmd;
            if (!hold_high) begin
               adc_strobe = 1'b0;
               ready = 1'b0;
               pending = fexp(rx_cmd);
               conv_timer = conv_enable ? CONV_CYC : 0;
            end
         end
      end
   end

   always @(posedge clk) begin
      if (conv_timer > 0) begin
         conv_timer--;
         if (conv_timer == 0) begin
            res_reg = pending;
            ready = 1'b1;
            adc_strobe = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && bus_grant && (!cs_n || sclk)) grant_bad = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   task automatic pulse_start(input logic [7:0] c);
      @(negedge clk);
      cmd_in = c;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_valid();
      @(negedge clk);
      while (!result_valid) @(negedge clk);
   endtask

   task automatic wait_grant();
      @(negedge clk);
      while (!bus_grant) @(negedge clk);
   endtask

   // {chain, cmd}
   localparam logic [8:0] VEC [0:7] = '{
      9'h0_8F, 9'h1_93, 9'h1_A6, 9'h1_C9, 9'h0_F0, 9'h1_B4, 9'h0_E1, 9'h0_D2
   };

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
   end

   initial begin
      bit chained_prev;
      int hc;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 bus pins", {cs_n, sclk, mosi}, 3'b100);
      chk(bus_grant == 1'b0 && busy == 1'b0 && timeout_err == 1'b0 && result_valid == 1'b0,
          "R1 status", {bus_grant, busy, timeout_err, result_valid}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && busy == 1'b0, "R1 after release", {cs_n, busy}, 2'b10);
      sclk_n = 0;

      // table of conversions, chained and not
      chained_prev = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic [8:0] v;
         v = VEC[i];
         if (!chained_prev) pulse_start(v[7:0]);
         chain_en = v[8];
         cmd_in = (i < 7) ? VEC[i+1][7:0] : 8'h00;
         if (i == 0) begin
            wait_grant();
            chk(last_cmd == v[7:0], "R2 command byte", last_cmd, v[7:0]);
            chk(cs_n == 1'b1 && sclk == 1'b0, "R3 released during wait", {cs_n, sclk}, 2'b10);
            chk(busy == 1'b1, "R9 busy while waiting", busy, 1);
         end
         wait_valid();
         chk(result == fexp(v[7:0]), "R5 result", result, fexp(v[7:0]));
         chk(sclk_n == (chained_prev ? 16 : 24), "R6 clocks per conversion", sclk_n,
             chained_prev ? 16 : 24);
         sclk_n = 0;
         chained_prev = v[8];
      end
      chain_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1, "R6 unchained returns idle", {busy, cs_n}, 2'b01);
      chk(grant_bad == 1'b0, "R3 grant monitor", grant_bad, 0);

      // R8 start ignored while busy
      sclk_n = 0;
      pulse_start(8'hA5);
      wait_grant();
      pulse_start(8'h9C);
      wait_valid();
      chk(result == fexp(8'hA5), "R8 result kept", result, fexp(8'hA5));
      chk(last_cmd == 8'hA5, "R8 no extra command", last_cmd, 8'hA5);
      chk(sclk_n == 24, "R8 no extra frame", sclk_n, 24);
      repeat (2) @(negedge clk);

      // R10 SCLK phase length
      pulse_start(8'hC3);
      @(posedge sclk);
      hc = 0;
      @(negedge clk);
      while (sclk) begin
         hc++;
         @(negedge clk);
      end
      chk(hc == DIV, "R10 high phase", hc, DIV);
      hc = 0;
      while (!sclk) begin
         hc++;
         @(negedge clk);
      end
      chk(hc == DIV, "R10 low phase", hc, DIV);
      wait_valid();
      chk(result == fexp(8'hC3), "R5 result after phase check", result, fexp(8'hC3));
      repeat (2) @(negedge clk);

      // R4 / R7: strobe stays high, so the wait must time out
      hold_high = 1'b1;
      timeout_lim = TW'(300);
      sclk_n = 0;
      pulse_start(8'hB1);
      wait_grant();
      repeat (280) @(negedge clk);
      chk(timeout_err == 1'b0 && bus_grant == 1'b1, "R7 not early", {timeout_err, bus_grant}, 2'b01);
      repeat (40) @(negedge clk);
      chk(timeout_err == 1'b1, "R7 error raised", timeout_err, 1);
      chk(busy == 1'b0 && cs_n == 1'b1 && bus_grant == 1'b0, "R7 back to idle",
          {busy, cs_n, bus_grant}, 3'b010);
      chk(sclk_n == 8, "R4 high level gave no readout", sclk_n, 8);

      // recovery clears the flag
      hold_high = 1'b0;
      timeout_lim = TW'(2000);
      pulse_start(8'hD7);
      chk(timeout_err == 1'b0, "R7 cleared by start", timeout_err, 0);
      wait_valid();
      chk(result == fexp(8'hD7), "R4 result after recovery", result, fexp(8'hD7));

      summary();
      $finish;
   end
endmodule